// File: doc/BRIEF.md
# Pin Change Interrupt Unit

This block watches a parameterised group of digital input pins (22 by default) and raises an interrupt request when any enabled pin no longer matches the value software captured at its last port read. Each pin is brought into the clock domain through a two-stage synchronizer. The synchronized value is then compared against a snapshot register. Software reloads the snapshot by pulsing a port-read strobe, which also clears the mismatch.

A small write/readback register interface holds the settings: a module-on bit, a per-pin watch mask, a per-pin weak pull-up mask, a 3-bit priority and a 2-bit subpriority, the interrupt flag and an interrupt enable. The pull-up mask drives the pull-up control lines directly. The priority fields are presented beside the request so that an external arbiter can use them.

The flag is held by a two-state machine. In FLAG_IDLE it moves to FLAG_PEND on any cycle where a mismatch exists. In FLAG_PEND it returns to FLAG_IDLE only on a clear write made while there is no mismatch. A clear write made while a mismatch is still present leaves the machine in FLAG_PEND. So software must pulse the port-read strobe before the clear can succeed.

Top module: `pin_change_irq`

## Requirements
- R1: Each pin passes through two synchronizer flops. A pin change driven before clock edge k is visible to the comparison after edge k+1, and the flag is set after edge k+2 and not earlier.
- R2: When the module-on bit (address 0, bit 0) is 0, no pin change sets the flag, and a clear write always succeeds.
- R3: `irq` is 1 exactly when all of the following hold: the flag is set, the interrupt enable (address 5, bit 0) is 1, the module-on bit is 1, and at least one watch-mask bit is set.
- R4: A mismatch exists when some pin whose watch-mask bit (address 1, bit i for pin i) is 1 has a synchronized value that differs from its snapshot bit, with the module on. Changes on unwatched pins have no effect. Once set, the flag stays set until a successful clear.
- R5: A one-cycle `port_rd` pulse loads the snapshot with the synchronized pin values at that edge. The snapshot appears on `port_data` and at address 6, and the mismatch ends.
- R6: Writing address 4 with bit 0 = 0 clears the flag, but only if no mismatch exists in that cycle. Otherwise the flag stays set. Writing bit 0 = 1 has no effect.
- R7: Address 3 holds the priority in bits [2:0] and the subpriority in bits [4:3]. These values drive `irq_prio` and `irq_sub`.
- R8: `pull_up` equals the pull-up mask (address 2) one cycle after it is written, whatever the module-on state.
- R9: After reset, all enables, both masks, the priority fields, the flag and the snapshot are 0, and `irq` is 0.
- R10: `rd_data` returns the register selected by `rd_addr` combinationally: 0 on, 1 watch mask, 2 pull-up mask, 3 priority fields, 4 flag, 5 interrupt enable, 6 snapshot, 7 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | N | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | N | Register write data |
| rd_addr | input | 3 | Readback address |
| rd_data | output | N | Readback data |
| port_rd | input | 1 | Port-read strobe, loads the snapshot |
| port_data | output | N | Current snapshot |
| irq | output | 1 | Interrupt request |
| irq_prio | output | 3 | Interrupt priority |
| irq_sub | output | 2 | Interrupt subpriority |
| pull_up | output | N | Weak pull-up enables |

## Verification
A pin edge reaches the flag three clock edges after it is driven: two synchronizer stages and then the flag register. A register write or a port-read strobe takes effect one edge later. Readback is combinational and is due in the same cycle. All stimulus changes just after a rising edge, and a cycle-accurate model in the bench advances on the same edges. Every output is compared on the falling edge. The directed cases sample exactly at the edge where the flag is due and also one edge before it.

// File: rtl/pcn_pkg.sv
package pcn_pkg;
    localparam int ADDR_W = 3;
    localparam int PRIO_W = 3;
    localparam int SUB_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_ON    = 3'd0,
        A_WATCH = 3'd1,
        A_PULL  = 3'd2,
        A_LEVEL = 3'd3,
        A_FLAG  = 3'd4,
        A_IE    = 3'd5,
        A_SNAP  = 3'd6,
        A_NONE  = 3'd7
    } reg_addr_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;
endpackage

// File: rtl/pcn_sync.sv
module pcn_sync #(
    parameter int W      = 22,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pcn_detect.sv
module pcn_detect #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_pins,
    input  logic         port_rd,
    input  logic         module_on,
    input  logic [W-1:0] watch_mask,
    output logic [W-1:0] snap,
    output logic         mismatch
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap <= '0;
        else if (port_rd) snap <= sync_pins;
    end

    assign mismatch = module_on && (|((sync_pins ^ snap) & watch_mask));
endmodule

// File: rtl/pcn_flag_fsm.sv
module pcn_flag_fsm
    import pcn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch,
    input  logic clr_req,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (mismatch) state_d = FLAG_PEND;
            FLAG_PEND: if (clr_req && !mismatch) state_d = FLAG_IDLE;
            default:   state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_PEND);
    end
endmodule

// File: rtl/pcn_regs.sv
module pcn_regs
    import pcn_pkg::*;
#(
    parameter int W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              flag,
    input  logic [W-1:0]      snap,
    output logic [W-1:0]      rd_data,
    output logic              module_on,
    output logic [W-1:0]      watch_mask,
    output logic [W-1:0]      pull_mask,
    output logic [PRIO_W-1:0] prio,
    output logic [SUB_W-1:0]  sub,
    output logic              irq_en,
    output logic              clr_req
);
    localparam int LEVEL_W = PRIO_W + SUB_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            module_on  <= 1'b0;
            watch_mask <= '0;
            pull_mask  <= '0;
            prio       <= '0;
            sub        <= '0;
            irq_en     <= 1'b0;
        end else if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                A_ON:    module_on  <= wr_data[0];
                A_WATCH: watch_mask <= wr_data;
                A_PULL:  pull_mask  <= wr_data;
                A_LEVEL: {sub, prio} <= wr_data[LEVEL_W-1:0];
                A_IE:    irq_en     <= wr_data[0];
                default: ;
            endcase
        end
    end

    assign clr_req = wr_en && (reg_addr_e'(wr_addr) == A_FLAG) && !wr_data[0];

    always_comb begin
        rd_data = '0;
        unique case (reg_addr_e'(rd_addr))
            A_ON:    rd_data[0] = module_on;
            A_WATCH: rd_data = watch_mask;
            A_PULL:  rd_data = pull_mask;
            A_LEVEL: rd_data[LEVEL_W-1:0] = {sub, prio};
            A_FLAG:  rd_data[0] = flag;
            A_IE:    rd_data[0] = irq_en;
            A_SNAP:  rd_data = snap;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
    import pcn_pkg::*;
#(
    parameter int N = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      pins_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [N-1:0]      rd_data,
    input  logic              port_rd,
    output logic [N-1:0]      port_data,
    output logic              irq,
    output logic [PRIO_W-1:0] irq_prio,
    output logic [SUB_W-1:0]  irq_sub,
    output logic [N-1:0]      pull_up
);
    logic [N-1:0] sync_pins;
    logic [N-1:0] snap;
    logic [N-1:0] watch_mask;
    logic [N-1:0] pull_mask;
    logic         module_on;
    logic         irq_en;
    logic         clr_req;
    logic         mismatch;
    logic         flag_q;

    pcn_sync #(.W(N), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_in),
        .q     (sync_pins)
    );

    pcn_detect #(.W(N)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pins  (sync_pins),
        .port_rd    (port_rd),
        .module_on  (module_on),
        .watch_mask (watch_mask),
        .snap       (snap),
        .mismatch   (mismatch)
    );

    pcn_flag_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mismatch (mismatch),
        .clr_req  (clr_req),
        .flag     (flag_q)
    );

    pcn_regs #(.W(N)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .flag       (flag_q),
        .snap       (snap),
        .rd_data    (rd_data),
        .module_on  (module_on),
        .watch_mask (watch_mask),
        .pull_mask  (pull_mask),
        .prio       (irq_prio),
        .sub        (irq_sub),
        .irq_en     (irq_en),
        .clr_req    (clr_req)
    );

    assign port_data = snap;
    assign pull_up   = pull_mask;
    assign irq       = flag_q && irq_en && module_on && (|watch_mask);
endmodule

// File: rtl/pcn_checker.sv
module pcn_checker
    import pcn_pkg::*;
#(
    parameter int N = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [N-1:0]      wr_data,
    input logic              port_rd,
    input logic [N-1:0]      port_data,
    input logic [N-1:0]      sync_pins,
    input logic              irq,
    input logic [N-1:0]      pull_up,
    input logic              mismatch,
    input logic              flag_q,
    input logic              module_on
);
    logic clr_w;
    assign clr_w = wr_en && (wr_addr == A_FLAG) && !wr_data[0];

    a_r4_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> flag_q);

    a_r6_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && mismatch && clr_w) |=> flag_q);

    a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !mismatch && clr_w) |=> !flag_q);

    a_r2_off_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!module_on && !flag_q) |=> !flag_q);

    a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |=> (port_data == $past(sync_pins)));

    a_r8_pull_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PULL) |=> (pull_up == $past(wr_data)));

    a_r3_ie_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_IE && !wr_data[0]) |=> !irq);

    a_r3_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);
endmodule

bind pin_change_irq pcn_checker #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .port_rd   (port_rd),
    .port_data (port_data),
    .sync_pins (sync_pins),
    .irq       (irq),
    .pull_up   (pull_up),
    .mismatch  (mismatch),
    .flag_q    (flag_q),
    .module_on (module_on)
);

// File: tb/test_pin_change_irq.sv
module test_pin_change_irq;
    localparam int N      = 22;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pins_in = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [N-1:0] rd_data;
    logic         port_rd = 1'b0;
    logic [N-1:0] port_data;
    logic         irq;
    logic [2:0]   irq_prio;
    logic [1:0]   irq_sub;
    logic [N-1:0] pull_up;

    int checks = 0;
    int fails  = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    pin_change_irq #(.N(N)) i_pin_change_irq (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .port_rd(port_rd), .port_data(port_data),
        .irq(irq), .irq_prio(irq_prio), .irq_sub(irq_sub), .pull_up(pull_up)
    );

    // Cycle-accurate model built from the requirements
    logic [N-1:0] m_s1, m_s2, m_snap, m_watch, m_pull;
    logic         m_on, m_ie, m_flag;
    logic [2:0]   m_prio;
    logic [1:0]   m_sub;

    function automatic logic m_mismatch();
        return m_on && (|((m_s2 ^ m_snap) & m_watch));
    endfunction

    function automatic logic exp_irq();
        return m_flag && m_ie && m_on && (|m_watch);
    endfunction

    function automatic logic [N-1:0] exp_rd(input logic [2:0] a);
        logic [N-1:0] r;
        r = '0;
        case (a)
            3'd0: r[0] = m_on;
            3'd1: r = m_watch;
            3'd2: r = m_pull;
            3'd3: r[4:0] = {m_sub, m_prio};
            3'd4: r[0] = m_flag;
            3'd5: r[0] = m_ie;
            3'd6: r = m_snap;
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_snap <= '0; m_watch <= '0; m_pull <= '0;
            m_on <= 1'b0; m_ie <= 1'b0; m_flag <= 1'b0; m_prio <= '0; m_sub <= '0;
        end else begin
            logic mis, clr;
            mis = m_mismatch();
            clr = wr_en && wr_addr == 3'd4 && !wr_data[0];
            if (m_flag) m_flag <= !(clr && !mis);
            else        m_flag <= mis;
            if (port_rd) m_snap <= m_s2;
            m_s2 <= m_s1;
            m_s1 <= pins_in;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_on <= wr_data[0];
                    3'd1: m_watch <= wr_data;
                    3'd2: m_pull <= wr_data;
                    3'd3: {m_sub, m_prio} <= wr_data[4:0];
                    3'd5: m_ie <= wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check("R3 irq vs model", 32'(irq), 32'(exp_irq()));
            check("R7 priority vs model", 32'({irq_sub, irq_prio}), 32'({m_sub, m_prio}));
            check("R8 pull_up vs model", 32'(pull_up), 32'(m_pull));
            check("R5 port_data vs model", 32'(port_data), 32'(m_snap));
            check("R10 rd_data vs model", 32'(rd_data), 32'(exp_rd(rd_addr)));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic pread();
        port_rd = 1'b1;
        tick(1);
        port_rd = 1'b0;
    endtask

    task automatic rd_at_neg(input logic [2:0] a, output logic [N-1:0] v);
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
        tick(0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'd1234));
        tick(3);
        @(negedge clk);
        // R9: reset values
        check("R9 irq after reset", 32'(irq), 32'd0);
        check("R9 pull_up after reset", 32'(pull_up), 32'd0);
        check("R9 snapshot after reset", 32'(port_data), 32'd0);
        check("R9 priority after reset", 32'({irq_sub, irq_prio}), 32'd0);
        rst_n = 1'b1;
        tick(1);
        model_on = 1'b1;
        for (int a = 0; a < 8; a++) begin
            rd_at_neg(3'(a), v);
            check("R9 register zero after reset", 32'(v), 32'd0);
        end

        // R8: pull-ups follow mask while module is off
        wr(3'd2, 22'h2A5A5A);
        @(negedge clk);
        check("R8 pull_up with module off", 32'(pull_up), 32'h2A5A5A);
        tick(0);

        // R7: priority fields
        wr(3'd3, 22'h15); // prio 5, sub 2
        @(negedge clk);
        check("R7 irq_prio", 32'(irq_prio), 32'd5);
        check("R7 irq_sub", 32'(irq_sub), 32'd2);
        tick(0);

        wr(3'd0, 22'h1);
        wr(3'd1, 22'h8);   // watch pin 3
        wr(3'd5, 22'h1);

        // R4: unwatched pin changes ignored
        pins_in[5] = 1'b1;
        tick(4);
        rd_at_neg(3'd4, v);
        check("R4 unwatched pin leaves flag clear", 32'(v), 32'd0);

        // R1: watched pin, flag due on third edge
        pins_in[3] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 flag not set after two edges", 32'(irq), 32'd0);
        @(posedge clk);
        @(negedge clk);
        check("R1 R3 irq set after third edge", 32'(irq), 32'd1);
        tick(0);

        // R6: clear blocked while mismatch persists
        wr(3'd4, 22'h0);
        @(negedge clk);
        check("R6 clear blocked by mismatch", 32'(irq), 32'd1);
        tick(0);
        // R6: writing 1 has no effect
        pread();
        wr(3'd4, 22'h1);
        @(negedge clk);
        check("R6 write of one leaves flag", 32'(irq), 32'd1);
        check("R5 snapshot holds pins", 32'(port_data), 32'h28);
        tick(0);
        wr(3'd4, 22'h0);
        rd_at_neg(3'd4, v);
        check("R5 R6 clear after port read", 32'(v), 32'd0);

        // R3: gating by interrupt enable and watch mask
        wr(3'd5, 22'h0);
        pins_in[3] = 1'b0;
        tick(4);
        rd_at_neg(3'd4, v);
        check("R3 flag set with ie off", 32'(v), 32'd1);
        check("R3 irq low with ie off", 32'(irq), 32'd0);
        wr(3'd5, 22'h1);
        @(negedge clk);
        check("R3 irq high with ie on", 32'(irq), 32'd1);
        tick(0);
        wr(3'd1, 22'h0);
        @(negedge clk);
        check("R3 irq low with no watched pins", 32'(irq), 32'd0);
        tick(0);
        wr(3'd1, 22'h8);

        // R2: module off
        wr(3'd0, 22'h0);
        wr(3'd4, 22'h0);
        rd_at_neg(3'd4, v);
        check("R2 clear succeeds with module off", 32'(v), 32'd0);
        pins_in[3] = 1'b1;
        tick(5);
        rd_at_neg(3'd4, v);
        check("R2 no flag with module off", 32'(v), 32'd0);
        pread();
        wr(3'd0, 22'h1);

        // Random phase, checked against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 5 == 0) pins_in[$urandom % N] ^= 1'b1;
            port_rd = ($urandom % 6 == 0);
            wr_en = ($urandom % 5 == 0);
            wr_addr = 3'($urandom % 8);
            wr_data = N'($urandom);
            if (wr_addr == 3'd0 || wr_addr == 3'd5) wr_data[0] = ($urandom % 4 != 0);
            if (wr_addr == 3'd4) wr_data[0] = ($urandom % 4 == 0);
            rd_addr = 3'($urandom % 8);
            tick(1);
        end
        wr_en = 1'b0;
        port_rd = 1'b0;
        tick(2);
        summary();
    end
endmodule